// File: doc/BRIEF.md
# Fractional Decimation Input Throttle

This block sets the timing of a fixed-ratio fractional decimator that turns Q input samples into P output samples, for example 3 outputs for every 5 inputs. It does no filter arithmetic. It keeps count of buffered input samples and decides in which clock cycle the filter may produce its next output. It also reports how many buffered inputs that output uses up, and which polyphase branch the output belongs to.

Input samples arrive on a valid/ready stream. The source may send one sample per clock until the local buffer is full. After that, ready stays low until an output frees space. Outputs are paced by a configured period in clock cycles. When the period has elapsed but too few inputs are buffered, the output waits for the data, and the period restarts from the cycle that output is issued.

The control is a two-state machine. ST_RUN means the period counter is running or the output can be issued on time. ST_STARVE means the period has elapsed and the block is waiting for input data. The transitions are:
- T_STARVE: ST_RUN goes to ST_STARVE when the period has elapsed and too few inputs are buffered.
- T_FEED: ST_STARVE goes back to ST_RUN on the cycle the buffer holds enough inputs; the output is issued in that cycle.
- T_ONTIME: ST_RUN stays in ST_RUN when it issues an output on time.
- T_COUNT: ST_RUN stays in ST_RUN while the period counter is still counting.

Top module: `fdt_dec_throttle`

## Requirements
- R1: After reset, out_valid is 0, s_tready is 1, out_phase is 0 and out_take is 0.
- R2: s_tready is 1 exactly when fewer than BUF_DEPTH inputs are buffered. A sample is taken into the buffer in each cycle where s_tvalid and s_tready are both 1.
- R3: The output whose phase is r uses ceil((r+Q)/P) - (r>0 ? 1 : 0) inputs, and out_take reports this number. For 3/5 this gives the repeating count 2, 2, 1 per output, which is 5 inputs per 3 outputs.
- R4: An output is issued only when the buffer, as it stood before that clock edge, holds at least the number of inputs that output needs, and the configured period has elapsed.
- R5: The period counter starts at 0 after reset and after each output. The period has elapsed once the counter has reached cfg_period-1. A value of 0 is treated as 1. When data is ready on time, consecutive outputs are exactly cfg_period cycles apart.
- R6: If the period has elapsed without enough data, the output is issued in the first cycle the buffer holds enough inputs. The next period counts from that output.
- R7: The phase of the first output is 0. Each later output's phase is the previous phase plus (Q mod P), taken modulo P, so the phase returns to 0 every P outputs. out_phase and out_take take new values only when out_valid is 1, and hold them otherwise.
- R8: In a cycle that both takes a sample and issues an output, the buffer count becomes old + 1 - take. A full buffer raises s_tready again in the cycle after an output frees space.
- R9: out_valid is a one-cycle strobe registered from the decision cycle. The output decided in cycle n shows out_valid=1 in cycle n+1, together with its phase and take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | PER_W | Output period in clock cycles (0 acts as 1) |
| s_tvalid | input | 1 | Input sample valid |
| s_tready | output | 1 | Buffer has room for a sample |
| out_valid | output | 1 | One-cycle strobe: filter output issued |
| out_phase | output | PH_W | Polyphase branch of the issued output |
| out_take | output | NEED_W | Buffered inputs released by this output |

## Verification
Taking in a sample and releasing samples for an output can happen in the same cycle. The case that matters is a full buffer with s_tready low, where the release must reopen the input exactly one cycle later. The bench provokes this with a continuous source and long output periods, so the buffer fills and stays at the edge of full. It also uses bursty and sparse sources, which make the release meet a half-full buffer. In every cycle, s_tready is compared with a count that the bench keeps from the buffer-count rule, and the strobe, phase and take are compared with a model of the period and ratio pattern.

// File: rtl/fdt_pkg.sv
package fdt_pkg;

    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_STARVE = 1'b1
    } fdt_state_e;

    // inputs consumed by the output at residue r of a Q-in / P-out decimator
    function automatic int fdt_need(input int r, input int p, input int q);
        return ((r + q + p - 1) / p) - ((r > 0) ? 1 : 0);
    endfunction

endpackage

// File: rtl/fdt_phase_seq.sv
module fdt_phase_seq #(
    parameter int RATE_P = 3,
    parameter int RATE_Q = 5,
    parameter int PH_W   = 2,
    parameter int NEED_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [PH_W-1:0]   phase,
    output logic [NEED_W-1:0] need
);
    import fdt_pkg::*;

    localparam int STEP = RATE_Q % RATE_P;

    logic [NEED_W-1:0] need_lut [RATE_P];

    for (genvar g = 0; g < RATE_P; g++) begin : g_lut
        assign need_lut[g] = NEED_W'(fdt_need(g, RATE_P, RATE_Q));
    end

    logic [PH_W:0]   sum;
    logic [PH_W-1:0] phase_n;

    always_comb begin
        sum = {1'b0, phase} + (PH_W+1)'(STEP);
        if (int'(sum) >= RATE_P) begin
            sum = sum - (PH_W+1)'(RATE_P);
        end
        phase_n = sum[PH_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (adv) begin
            phase <= phase_n;
        end
    end

    assign need = need_lut[phase];

endmodule

// File: rtl/fdt_fill_ctr.sv
module fdt_fill_ctr #(
    parameter int BUF_DEPTH = 4,
    parameter int OCC_W     = 3,
    parameter int NEED_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              take_en,
    input  logic [NEED_W-1:0] take_n,
    output logic [OCC_W-1:0]  occ,
    output logic              ready
);
    logic              acc;
    logic [OCC_W-1:0]  occ_n;

    assign ready = (occ != OCC_W'(BUF_DEPTH));
    assign acc   = in_valid && ready;

    always_comb begin
        occ_n = occ;
        if (acc) begin
            occ_n = occ_n + OCC_W'(1);
        end
        if (take_en) begin
            occ_n = occ_n - OCC_W'(take_n);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else begin
            occ <= occ_n;
        end
    end

endmodule

// File: rtl/fdt_period_tmr.sv
module fdt_period_tmr #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period,
    input  logic             restart,
    output logic             elapsed
);
    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] last;

    assign last    = (period == '0) ? '0 : period - PER_W'(1);
    assign elapsed = (cnt >= last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (!elapsed) begin
            cnt <= cnt + PER_W'(1);
        end
    end

endmodule

// File: rtl/fdt_dec_throttle.sv
module fdt_dec_throttle #(
    parameter int RATE_P    = 3,
    parameter int RATE_Q    = 5,
    parameter int BUF_DEPTH = 4,
    parameter int PER_W     = 8,
    parameter int PH_W      = (RATE_P > 1) ? $clog2(RATE_P) : 1,
    parameter int NEED_W    = $clog2(((RATE_Q + RATE_P - 1) / RATE_P) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  cfg_period,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic              out_valid,
    output logic [PH_W-1:0]   out_phase,
    output logic [NEED_W-1:0] out_take
);
    import fdt_pkg::*;

    localparam int OCC_W = $clog2(BUF_DEPTH + 1);

    fdt_state_e        state, state_n;
    logic              elapsed;
    logic              enough;
    logic              fire;
    logic [PH_W-1:0]   phase;
    logic [NEED_W-1:0] need;
    logic [OCC_W-1:0]  occ;

    fdt_phase_seq #(
        .RATE_P (RATE_P),
        .RATE_Q (RATE_Q),
        .PH_W   (PH_W),
        .NEED_W (NEED_W)
    ) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (fire),
        .phase (phase),
        .need  (need)
    );

    fdt_fill_ctr #(
        .BUF_DEPTH (BUF_DEPTH),
        .OCC_W     (OCC_W),
        .NEED_W    (NEED_W)
    ) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (s_tvalid),
        .take_en  (fire),
        .take_n   (need),
        .occ      (occ),
        .ready    (s_tready)
    );

    fdt_period_tmr #(
        .PER_W (PER_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .period  (cfg_period),
        .restart (fire),
        .elapsed (elapsed)
    );

    assign enough = (int'(occ) >= int'(need));

    always_comb begin
        state_n = state;
        fire    = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (elapsed && enough) begin
                    fire = 1'b1;          // T_ONTIME
                end else if (elapsed) begin
                    state_n = ST_STARVE;  // T_STARVE
                end
            end
            ST_STARVE: begin
                if (enough) begin
                    fire    = 1'b1;
                    state_n = ST_RUN;     // T_FEED
                end
            end
            default: state_n = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_phase <= '0;
            out_take  <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_phase <= phase;
                out_take  <= need;
            end
        end
    end

endmodule

// File: rtl/fdt_dec_throttle_chk.sv
module fdt_dec_throttle_chk #(
    parameter int RATE_P    = 3,
    parameter int RATE_Q    = 5,
    parameter int BUF_DEPTH = 4,
    parameter int PH_W      = 2,
    parameter int NEED_W    = 2,
    parameter int OCC_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_tvalid,
    input logic              s_tready,
    input logic              out_valid,
    input logic [PH_W-1:0]   out_phase,
    input logic [NEED_W-1:0] out_take,
    input logic [OCC_W-1:0]  occ
);
    localparam int MAX_NEED = (RATE_Q + RATE_P - 1) / RATE_P;
    localparam int STEP     = RATE_Q % RATE_P;

    logic             armed;
    logic [OCC_W-1:0] prev_occ;
    logic             prev_acc;
    logic             have_last;
    logic [PH_W-1:0]  last_phase;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            prev_occ   <= '0;
            prev_acc   <= 1'b0;
            have_last  <= 1'b0;
            last_phase <= '0;
        end else begin
            armed    <= 1'b1;
            prev_occ <= occ;
            prev_acc <= s_tvalid && s_tready;
            if (out_valid) begin
                have_last  <= 1'b1;
                last_phase <= out_phase;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= BUF_DEPTH) else $error("occupancy above depth"); // R2

    AST_OCC_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (int'(occ) == int'(prev_occ) + int'(prev_acc)
                   - (out_valid ? int'(out_take) : 0))) else $error("occupancy balance"); // R8

    AST_ENOUGH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && out_valid) |-> (int'(prev_occ) >= int'(out_take))) else $error("output without data"); // R4

    AST_TAKE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_take != '0 && int'(out_take) <= MAX_NEED)) else $error("take out of range"); // R3

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && have_last) |->
            (int'(out_phase) == (int'(last_phase) + STEP) % RATE_P)) else $error("phase step"); // R7

    AST_FIRST_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !have_last) |-> (out_phase == '0)) else $error("first phase"); // R7

endmodule

bind fdt_dec_throttle fdt_dec_throttle_chk #(
    .RATE_P    (RATE_P),
    .RATE_Q    (RATE_Q),
    .BUF_DEPTH (BUF_DEPTH),
    .PH_W      (PH_W),
    .NEED_W    (NEED_W),
    .OCC_W     ($clog2(BUF_DEPTH + 1))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_tvalid  (s_tvalid),
    .s_tready  (s_tready),
    .out_valid (out_valid),
    .out_phase (out_phase),
    .out_take  (out_take),
    .occ       (occ)
);

// File: tb/fdt_dec_throttle_tb.sv
`timescale 1ns/1ps
module fdt_dec_throttle_tb;
    localparam int P     = 3;
    localparam int Q     = 5;
    localparam int DEPTH = 4;
    localparam int PER_W = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_period = 8'd1;
    logic       s_tvalid = 1'b0;
    logic       s_tready;
    logic       out_valid;
    logic [1:0] out_phase;
    logic [1:0] out_take;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    fdt_dec_throttle #(
        .RATE_P (P), .RATE_Q (Q), .BUF_DEPTH (DEPTH), .PER_W (PER_W)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .cfg_period (cfg_period),
        .s_tvalid (s_tvalid), .s_tready (s_tready),
        .out_valid (out_valid), .out_phase (out_phase), .out_take (out_take)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int need_ref(input int k);
        return cdiv((k + 1) * Q, P) - cdiv(k * Q, P);
    endfunction

    task automatic run(input int per, input int mode, input int ncyc);
        int occ = 0, cnt = 0, k = 0;
        int ov = 0, oph = 0, otk = 0;
        int nout = 0, last_cyc = -1;
        bit saw_full = 1'b0;
        int pm1 = (per == 0) ? 0 : per - 1;
        rst_n      = 1'b0;
        s_tvalid   = 1'b0;
        cfg_period = 8'(per);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(s_tready == 1'b1, "R1 s_tready", int'(s_tready), 1);
        check(out_phase == 2'd0, "R1 out_phase", int'(out_phase), 0);
        check(out_take == 2'd0, "R1 out_take", int'(out_take), 0);
        for (int i = 0; i < ncyc; i++) begin
            bit v, rdy, acc, el, fire;
            int nd;
            // compare outputs with model state after the last edge
            check(s_tready == (occ != DEPTH), "R2/R8 s_tready", int'(s_tready), int'(occ != DEPTH));
            if (occ == DEPTH) saw_full = 1'b1;
            check(int'(out_valid) == ov, "R4/R6/R9 out_valid", int'(out_valid), ov);
            if (out_valid && ov == 1) begin
                check(int'(out_phase) == oph, "R7 out_phase", int'(out_phase), oph);
                check(int'(out_take) == otk, "R3 out_take", int'(out_take), otk);
                if (P == 3 && Q == 5) begin
                    int lit;
                    lit = (nout % 3 == 2) ? 1 : 2;
                    check(int'(out_take) == lit, "R3 2-2-1 pattern", int'(out_take), lit);
                end
                if (mode == 0 && per >= 2 && nout >= 2)
                    check(i - last_cyc == per, "R5 spacing", i - last_cyc, per);
                nout++;
                last_cyc = i;
            end
            // drive this cycle's input
            unique case (mode)
                0: v = 1'b1;
                1: v = (i % 2 == 0);
                2: v = (i % 3 == 0);
                3: v = lfsr[0];
                default: v = ((i / 8) % 2 == 0);
            endcase
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s_tvalid = v;
            // model step from the requirements
            rdy  = (occ != DEPTH);
            acc  = v && rdy;
            el   = (cnt >= pm1);
            nd   = need_ref(k);
            fire = el && (occ >= nd);
            ov   = fire ? 1 : 0;
            if (fire) begin
                oph = (k * Q) % P;
                otk = nd;
            end
            occ = occ + (acc ? 1 : 0) - (fire ? nd : 0);
            cnt = fire ? 0 : (el ? cnt : cnt + 1);
            k   = fire ? (k + 1) % P : k;
            @(posedge clk);
            @(negedge clk);
        end
        if (mode == 0 && per >= 4)
            check(saw_full, "R2 full buffer reached", int'(saw_full), 1);
        check(nout > 0, "R4 outputs produced", nout, 1);
        s_tvalid = 1'b0;
    endtask

    initial begin
        for (int per = 0; per <= 6; per++) begin
            for (int mode = 0; mode < 5; mode++) begin
                run(per, mode, 120);
            end
        end
        run(12, 0, 150);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule